// File: doc/BRIEF.md
# Multi-mode 16-bit reload timer

This block is a single 16-bit timer channel whose one counter serves three purposes, picked by a 2-bit mode field. In the prescaled mode it counts down on a tick from a power-of-two divider of the system clock. In the event mode it counts rising edges seen on an external pin. In the pulse-width mode it counts prescaler ticks up from zero while the external pin is high, so the result is the width of the pulse. The count is always visible on an output port.

In both down-counting modes the counter starts from a programmed reload value. On the step after zero it reloads and emits a one-cycle underflow pulse. That pulse can feed an interrupt request. It also flips a square-wave output that a serial interface can use as its bit clock. A write-only register port sets the mode, the divider tap and the reload value, and a separate run pin starts and halts counting.

Top module: `mm_reload_timer`

## Requirements
- R1: After reset the count, underflow pulse and serial clock output are 0, and the mode, clock-select and reload registers are 0.
- R2: A write with address 0 sets the mode from data bits [1:0], address 1 sets the clock select from data bits [3:0], and address 2 sets the reload value from data bits [15:0]. Writes to addresses 0 and 1 are ignored while run is high. Reload writes are always accepted.
- R3: An internal prescale counter is held at zero while run is low and increments on each cycle while run is high. With clock select N (0 to 14) a tick occurs on every cycle in which the low N bits of that counter are all ones, which gives one tick per 2^N cycles.
- R4: On the first cycle that run is high after being low, the count loads the reload value in modes 0, 1 and 3, or zero in mode 2. No counting step happens in that cycle.
- R5: In mode 0 each tick decrements the count. A tick at count 0 instead reloads the count from the reload register and asserts the underflow output for exactly that one cycle.
- R6: The serial clock output flips on every underflow pulse and at no other time.
- R7: In mode 1 the external input passes through two synchronizing flops. Each rising edge of the synchronized level acts as one step, with the same decrement, reload and underflow rules as mode 0.
- R8: In mode 2 each tick increments the count while the synchronized input is high, and the count holds while it is low. The count saturates at 0xFFFF, and no underflow is produced.
- R9: Mode 3 holds the count. Clock select 15 produces no ticks, so the count holds in modes 0 and 2.
- R10: While run is low the count, the underflow output (0) and the serial clock output hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 mode, 1 clock select, 2 reload |
| reg_wdata | input | 16 | Register write data |
| run | input | 1 | Counting enable; its rising edge loads the count |
| ext_in | input | 1 | External event or pulse input, asynchronous |
| count_val | output | 16 | Current counter value |
| uf_pulse | output | 1 | One-cycle underflow pulse |
| sclk_out | output | 1 | Square wave that flips on each underflow |

## Verification
The assertions take for granted that mode and clock select never change during a run. The design enforces this by ignoring such writes, and the stimulus also tries such writes mid-run to confirm they have no effect. The assertions also assume that ext_in, although asynchronous, is seen only through the synchronizer, so the bench drives it only on falling clock edges. It holds each level for random stretches of cycles, which gives both isolated edges and long pulses. Reload writes can arrive at any time, so the reload check compares against the value held one cycle before the underflow, not the current one.

// File: rtl/tmr_pkg.sv
// Package: shared types and register addresses for the reload timer.
// Assumes a 2-bit mode field and a 2-bit register address space.
package tmr_pkg;

    typedef enum logic [1:0] {
        MODE_INT = 2'd0,
        MODE_EVT = 2'd1,
        MODE_PW  = 2'd2,
        MODE_RSV = 2'd3
    } tmr_mode_e;

    localparam logic [1:0] ADDR_MODE   = 2'd0;
    localparam logic [1:0] ADDR_CSEL   = 2'd1;
    localparam logic [1:0] ADDR_RELOAD = 2'd2;

endpackage

// File: rtl/tmr_regs.sv
// Configuration registers: mode, clock select and reload value.
// Mode and clock-select writes are blocked while run is high, so the
// counter never sees its step source change mid-run. Reload is always
// writable and takes effect at the next load.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int CSEL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              run,
    output tmr_mode_e         mode_q,
    output logic [CSEL_W-1:0] csel_q,
    output logic [CNT_W-1:0]  reload_q
);

    // Register update on accepted writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= MODE_INT;
            csel_q   <= '0;
            reload_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_MODE:   if (!run) mode_q <= tmr_mode_e'(wr_data[1:0]);
                ADDR_CSEL:   if (!run) csel_q <= wr_data[CSEL_W-1:0];
                ADDR_RELOAD: reload_q <= wr_data;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/tmr_prescaler.sv
// Power-of-two prescaler: a free counter cleared while halted, plus a
// tap select that makes one tick every 2^csel cycles. Select values
// above STAGES are reserved and give no ticks.
module tmr_prescaler #(
    parameter int STAGES = 14,
    parameter int CSEL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CSEL_W-1:0] csel,
    output logic              tick
);

    localparam int MASK_W = 32;

    logic [STAGES-1:0] pcnt;
    logic [MASK_W-1:0] mask_wide;
    logic [STAGES-1:0] mask;
    logic              sel_ok;

    // Prescale counter: zero while halted, counts while running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) pcnt <= '0;
        else                pcnt <= pcnt + 1'b1;
    end

    // Tap decode: low csel bits all ones marks a tick.
    always_comb begin
        mask_wide = (MASK_W'(1) << csel) - MASK_W'(1);
        mask      = mask_wide[STAGES-1:0];
        sel_ok    = (32'(csel) <= STAGES);
        tick      = run && sel_ok && ((pcnt & mask) == mask);
    end

endmodule

// File: rtl/tmr_sync_edge.sv
// Synchronizer for the asynchronous external input, followed by a
// rising-edge detector. Gives the synchronized level and a one-cycle
// pulse per rising edge.
module tmr_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise
);

    logic [SYNC_STAGES:0] shreg;

    // Shift chain: SYNC_STAGES flops plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[SYNC_STAGES-1:0], din};
    end

    // Level and edge outputs.
    always_comb begin
        level = shreg[SYNC_STAGES-1];
        rise  = shreg[SYNC_STAGES-1] & ~shreg[SYNC_STAGES];
    end

endmodule

// File: rtl/tmr_count_core.sv
// Counter core. Loads on the run rising edge. In the down modes it
// decrements, and on the step after zero it reloads with a one-cycle
// underflow pulse that also flips the serial clock. In pulse-width mode
// it counts up while the level is high and saturates. Mode 3 holds.
module tmr_count_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  tmr_mode_e        mode,
    input  logic [CNT_W-1:0] reload,
    input  logic             tick,
    input  logic             ev_rise,
    input  logic             ev_level,
    output logic [CNT_W-1:0] cnt,
    output logic             uf,
    output logic             sclk
);

    logic run_q;
    logic start;
    logic down_step;
    logic up_step;

    // Step sources chosen by mode.
    always_comb begin
        start     = run && !run_q;
        down_step = 1'b0;
        up_step   = 1'b0;
        case (mode)
            MODE_INT: down_step = tick;
            MODE_EVT: down_step = ev_rise;
            MODE_PW:  up_step   = tick && ev_level;
            default:  ;
        endcase
    end

    // Counter, underflow pulse and serial clock state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt   <= '0;
            uf    <= 1'b0;
            sclk  <= 1'b0;
        end else begin
            run_q <= run;
            uf    <= 1'b0;
            if (start) begin
                cnt <= (mode == MODE_PW) ? '0 : reload;
            end else if (run && down_step) begin
                if (cnt == '0) begin
                    cnt  <= reload;
                    uf   <= 1'b1;
                    sclk <= ~sclk;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end else if (run && up_step && (cnt != '1)) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/mm_reload_timer.sv
// Top of the multi-mode reload timer. Wires the register block, the
// prescaler, the input synchronizer and the counter core together.
// Assumes ext_in is asynchronous and the register port is synchronous.
module mm_reload_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int PSC_STAGES  = 14,
    parameter int CSEL_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    input  logic             run,
    input  logic             ext_in,
    output logic [CNT_W-1:0] count_val,
    output logic             uf_pulse,
    output logic             sclk_out
);

    tmr_mode_e         mode_q;
    logic [CSEL_W-1:0] csel_q;
    logic [CNT_W-1:0]  reload_q;
    logic              tick;
    logic              ev_level;
    logic              ev_rise;

    tmr_regs #(.CNT_W(CNT_W), .CSEL_W(CSEL_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .wr_addr  (reg_addr),
        .wr_data  (reg_wdata),
        .run      (run),
        .mode_q   (mode_q),
        .csel_q   (csel_q),
        .reload_q (reload_q)
    );

    tmr_prescaler #(.STAGES(PSC_STAGES), .CSEL_W(CSEL_W)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .csel  (csel_q),
        .tick  (tick)
    );

    tmr_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ext_in),
        .level (ev_level),
        .rise  (ev_rise)
    );

    tmr_count_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .mode     (mode_q),
        .reload   (reload_q),
        .tick     (tick),
        .ev_rise  (ev_rise),
        .ev_level (ev_level),
        .cnt      (count_val),
        .uf       (uf_pulse),
        .sclk     (sclk_out)
    );

endmodule

// File: rtl/tmr_checker.sv
// Property checker for the reload timer, bound to the top module.
// Assumes mode cannot change while run is high, which the registers enforce.
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input tmr_mode_e        mode_q,
    input logic [CNT_W-1:0] reload_q,
    input logic             ev_rise,
    input logic [CNT_W-1:0] count_val,
    input logic             uf_pulse,
    input logic             sclk_out
);

    // R5: an underflow leaves the count equal to the reload value held before it.
    a_r5_uf_loads_reload: assert property (@(posedge clk) disable iff (!rst_n)
        uf_pulse |-> count_val == $past(reload_q));

    // R6: every underflow flips the serial clock.
    a_r6_sclk_flips: assert property (@(posedge clk) disable iff (!rst_n)
        uf_pulse |-> sclk_out != $past(sclk_out));

    // R6: the serial clock only changes together with an underflow.
    a_r6_sclk_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !uf_pulse |-> sclk_out == $past(sclk_out));

    // R7: in event mode the count moves only on a synchronized rising edge.
    a_r7_evt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && mode_q == MODE_EVT && !ev_rise) |=> $stable(count_val));

    // R8: pulse-width mode never decreases the count.
    a_r8_pw_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && mode_q == MODE_PW) |=> count_val >= $past(count_val));

    // R8: pulse-width mode produces no underflow.
    a_r8_pw_no_uf: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_PW) |-> !uf_pulse);

    // R9: the reserved mode holds the count.
    a_r9_rsv_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && mode_q == MODE_RSV) |=> $stable(count_val));

    // R10: a halted timer keeps its count.
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(count_val));

endmodule

bind mm_reload_timer tmr_checker #(.CNT_W(CNT_W)) u_tmr_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .mode_q    (mode_q),
    .reload_q  (reload_q),
    .ev_rise   (ev_rise),
    .count_val (count_val),
    .uf_pulse  (uf_pulse),
    .sclk_out  (sclk_out)
);

// File: tb/test_mm_reload_timer.sv
// Bench: a cycle model built from the requirements is compared every
// cycle against the outputs. Random segments are mixed with directed cases.
module test_mm_reload_timer;

    localparam int WATCHDOG = 180000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic        run = 1'b0;
    logic        ext_in = 1'b0;
    logic [15:0] count_val;
    logic        uf_pulse;
    logic        sclk_out;

    int n_chk = 0;
    int n_err = 0;
    bit model_on = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mm_reload_timer i_mm_reload_timer (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .run(run), .ext_in(ext_in),
        .count_val(count_val), .uf_pulse(uf_pulse), .sclk_out(sclk_out)
    );

    // Reference model state
    logic [1:0]  m_mode;
    logic [3:0]  m_cs;
    logic [15:0] m_rel, m_cnt;
    logic [13:0] m_p;
    logic        m_s1, m_s2, m_s3, m_runq, m_uf, m_sclk;

    function automatic bit tick_now(input logic [13:0] p, input logic [3:0] cs, input logic r);
        logic [31:0] mk;
        mk = (32'd1 << cs) - 32'd1;
        return r && (cs <= 4'd14) && ((32'(p) & mk) == mk);
    endfunction

    function automatic string mode_tag(input logic [1:0] md);
        case (md)
            2'd0: return "R5";
            2'd1: return "R7";
            2'd2: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Model update from the requirements R2..R10
    always @(posedge clk) begin
        bit tk, rs, dn, up;
        if (!rst_n) begin
            m_mode <= 2'd0; m_cs <= 4'd0; m_rel <= 16'd0; m_cnt <= 16'd0;
            m_p <= 14'd0; m_s1 <= 1'b0; m_s2 <= 1'b0; m_s3 <= 1'b0;
            m_runq <= 1'b0; m_uf <= 1'b0; m_sclk <= 1'b0;
        end else begin
            tk = tick_now(m_p, m_cs, run);
            rs = m_s2 && !m_s3;
            dn = (m_mode == 2'd0) ? tk : (m_mode == 2'd1) ? rs : 1'b0;
            up = (m_mode == 2'd2) && tk && m_s2;
            m_s1 <= ext_in; m_s2 <= m_s1; m_s3 <= m_s2;
            m_p <= run ? m_p + 14'd1 : 14'd0;
            m_runq <= run;
            m_uf <= 1'b0;
            if (reg_wr) begin
                if (reg_addr == 2'd0 && !run) m_mode <= reg_wdata[1:0];
                if (reg_addr == 2'd1 && !run) m_cs <= reg_wdata[3:0];
                if (reg_addr == 2'd2) m_rel <= reg_wdata;
            end
            if (run && !m_runq) m_cnt <= (m_mode == 2'd2) ? 16'd0 : m_rel;
            else if (run && dn) begin
                if (m_cnt == 16'd0) begin
                    m_cnt <= m_rel; m_uf <= 1'b1; m_sclk <= ~m_sclk;
                end else m_cnt <= m_cnt - 16'd1;
            end else if (run && up && m_cnt != 16'hFFFF) m_cnt <= m_cnt + 16'd1;
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (model_on && rst_n && !done) begin
            check(mode_tag(m_mode), 32'(count_val), 32'(m_cnt));
            check("R6", {30'd0, uf_pulse, sclk_out}, {30'd0, m_uf, m_sclk});
        end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rand_seg(input int cycles, input int ext_hold);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            reg_wr = 1'b0;
            if ($urandom % ext_hold == 0) ext_in = ~ext_in;
            if ($urandom % 97 == 0) begin
                reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 16'($urandom % 24);
            end else if ($urandom % 151 == 0) begin
                reg_wr = 1'b1; reg_addr = 2'($urandom % 2); reg_wdata = 16'($urandom);
            end
        end
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", {14'd0, uf_pulse, sclk_out, count_val}, 32'd0);
        model_on = 1'b1;

        // R4 + R3: mode 0, divide by 4, reload 100
        wr(2'd1, 16'd2); wr(2'd2, 16'd100);
        @(negedge clk); run = 1'b1;
        @(negedge clk); check("R4", 32'(count_val), 32'd100);
        @(negedge clk);
        @(negedge clk); check("R3", 32'(count_val), 32'd100);
        @(negedge clk); check("R3", 32'(count_val), 32'd99);
        // R2: clock-select write while running is ignored
        wr(2'd1, 16'd15);
        idle(6);
        check("R2", 32'(count_val), 32'd97);
        // R10: halt holds the count
        run = 1'b0;
        idle(20);
        check("R10", 32'(count_val), 32'd97);

        // R9: clock select 15 holds count in mode 0
        wr(2'd1, 16'd15); wr(2'd2, 16'd9);
        @(negedge clk); run = 1'b1;
        idle(30);
        check("R9", 32'(count_val), 32'd9);
        run = 1'b0;

        // R4: pulse-width start clears to zero
        wr(2'd0, 16'd2); wr(2'd1, 16'd0); wr(2'd2, 16'd7);
        @(negedge clk); run = 1'b1;
        @(negedge clk); check("R4", 32'(count_val), 32'd0);
        run = 1'b0;

        // R5/R6: reload 0 at full rate underflows every cycle
        wr(2'd0, 16'd0); wr(2'd2, 16'd0);
        @(negedge clk); run = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R5", {31'd0, uf_pulse}, 32'd1);
        idle(10);
        run = 1'b0;

        // Random segments over all modes and taps
        for (int s = 0; s < 60; s++) begin
            idle(1 + int'($urandom % 4));
            wr(2'd0, 16'($urandom % 4));
            wr(2'd1, ($urandom % 8 == 0) ? 16'd15 : 16'($urandom % 5));
            wr(2'd2, 16'($urandom % 20));
            @(negedge clk); run = 1'b1;
            rand_seg(50 + int'($urandom % 350), 2 + int'($urandom % 12));
            run = 1'b0;
        end

        // R8: long pulse saturates at 0xFFFF
        idle(2);
        wr(2'd0, 16'd2); wr(2'd1, 16'd0);
        ext_in = 1'b1;
        @(negedge clk); run = 1'b1;
        idle(66000);
        check("R8", 32'(count_val), 32'h0000FFFF);
        ext_in = 1'b0;
        idle(5);
        run = 1'b0;
        idle(3);
        finish_run();
    end

endmodule